// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

This unit carries out the bit-positioning operations of a 16-bit processor datapath: logical and arithmetic shifts, end-around rotates, rotates that pass through the carry flag, and two-register funnel shifts. Each request presents a destination operand, a second operand that feeds the funnel shifts, a shift count, an operation code, a size select and the current carry, zero, sign and overflow flags. One clock later the unit returns the result together with the updated flags.

The count is masked to its low five bits before use. A masked count of zero returns the operand and the incoming flags untouched. Byte-sized operations work on bits 7..0, take every flag from bit 7, and return zero in the upper byte. Both operand sizes are computed in parallel, in lanes generated from one width parameter, and one flag path serves every operation.

Top module: `srx_unit`

## Requirements
- R1: Op codes 0 (logical left) and 2 (arithmetic left) shift the operand left and fill bit 0 with zeros. The carry takes the last bit shifted out. A count at or above the operand width gives zero, and the carry is zero when the count is above the width.
- R2: Op code 1 (logical right) fills the top bit with zeros. The carry takes the last bit shifted out. A count at or above the width gives zero.
- R3: Op code 3 (arithmetic right) copies the sign bit into the vacated positions. A count at or above the width gives all sign bits, and the carry then equals the sign.
- R4: Op code 4 rotates left and op code 5 rotates right, each end-around over the operand width and taking the count modulo the width. The carry equals the bit that wrapped: the result's bit 0 for left and its top bit for right.
- R5: Op code 6 rotates left and op code 7 rotates right through a ring of width+1 bits, with the carry above the operand's top bit. The count is taken modulo width+1. The result is the low part of the ring and the carry is its top bit.
- R6: Op code 8 shifts the destination left and fills it from the source's top bits. Op code 9 shifts it right and fills it from the source's low bits, the source LSB entering first. Bits past both registers are zero. The carry takes the last destination bit shifted out.
- R7: Only count bits 4..0 are used. Bits 7..5 have no effect.
- R8: A masked count of zero returns the operand unchanged and passes all four incoming flags through.
- R9: With a masked count of one, overflow is the XOR of the result's sign bit and the operand's sign bit. For any other count, overflow passes through unchanged.
- R10: Shifts (codes 0-3, 8, 9) set zero when the result is zero and set sign from the result's top bit. Rotates (codes 4-7) pass zero and sign through.
- R11: Size select 1 works on 16 bits. Size select 0 works on bits 7..0, takes the flags from bit 7, ignores the upper operand bytes and drives result bits 15..8 to zero.
- R12: A request with valid high produces valid high with its result exactly one cycle later. Op codes 10-15 behave as a zero count. After reset, valid, result and flags are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 4 | Operation code |
| wide_i | input | 1 | 1 = 16-bit, 0 = 8-bit |
| opa_i | input | 16 | Destination operand |
| opb_i | input | 16 | Source operand for funnel shifts |
| count_i | input | 8 | Shift count, low 5 bits used |
| cf_i | input | 1 | Incoming carry |
| zf_i | input | 1 | Incoming zero flag |
| sf_i | input | 1 | Incoming sign flag |
| of_i | input | 1 | Incoming overflow flag |
| valid_o | output | 1 | Result strobe |
| result_o | output | 16 | Shifted or rotated value |
| cf_o | output | 1 | Updated carry |
| zf_o | output | 1 | Updated zero flag |
| sf_o | output | 1 | Updated sign flag |
| of_o | output | 1 | Updated overflow flag |

## Verification
The only state is the output register, so any fault in a lane, the modulo reduction or the flag selection shows on result_o or the flag outputs on the cycle after the request. A wrong modulo or a wrong fill source hides at small counts and appears only at counts near or past the operand width, or at the masked-count boundary. For that reason every operation is driven at all 32 counts in both sizes, and the upper count bits are toggled along the way. A flag that wrongly follows the result instead of passing through shows only when the incoming flag disagrees with what the result would imply, so the incoming flags vary across the sweep.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [3:0] {
    OP_SHL  = 4'd0,
    OP_SHR  = 4'd1,
    OP_SAL  = 4'd2,
    OP_SAR  = 4'd3,
    OP_ROL  = 4'd4,
    OP_ROR  = 4'd5,
    OP_RCL  = 4'd6,
    OP_RCR  = 4'd7,
    OP_SHLD = 4'd8,
    OP_SHRD = 4'd9
  } srx_op_e;

  function automatic logic is_rotate(logic [3:0] op);
    return op == OP_ROL || op == OP_ROR || op == OP_RCL || op == OP_RCR;
  endfunction

  function automatic logic is_shift(logic [3:0] op);
    return op == OP_SHL || op == OP_SHR || op == OP_SAL || op == OP_SAR ||
           op == OP_SHLD || op == OP_SHRD;
  endfunction

endpackage

// File: rtl/srx_shift_lane.sv
module srx_shift_lane
  import srx_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = 8
) (
  input  logic [3:0]       op_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [W-1:0]     res_o,
  output logic             carry_o
);

  logic is_left;
  logic [W-1:0] lo_fill, hi_fill;
  logic [2*W:0] lv, lt, rv, rt_log, rt_ar, rt;
  logic signed [2*W:0] rv_s;

  assign is_left = op_i == OP_SHL || op_i == OP_SAL || op_i == OP_SHLD;

  // left: {guard, dest, fill}; guard bit catches the last bit out
  assign lo_fill = (op_i == OP_SHLD) ? b_i : '0;
  assign lv      = {1'b0, a_i, lo_fill};
  assign lt      = lv << cnt_i;

  // right: {fill, dest, guard}
  always_comb begin
    if (op_i == OP_SAR)       hi_fill = {W{a_i[W-1]}};
    else if (op_i == OP_SHRD) hi_fill = b_i;
    else                      hi_fill = '0;
  end
  assign rv     = {hi_fill, a_i, 1'b0};
  assign rv_s   = rv;
  assign rt_log = rv >> cnt_i;
  assign rt_ar  = rv_s >>> cnt_i;
  assign rt     = (op_i == OP_SAR) ? rt_ar : rt_log;

  assign res_o   = is_left ? lt[2*W-1:W] : rt[W:1];
  assign carry_o = is_left ? lt[2*W]     : rt[0];

endmodule

// File: rtl/srx_rot_lane.sv
module srx_rot_lane
  import srx_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = 8
) (
  input  logic [3:0]       op_i,
  input  logic [W-1:0]     a_i,
  input  logic             cin_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [W-1:0]     res_o,
  output logic             carry_o
);

  localparam int N = W + 1;

  logic [CNT_W-1:0] k_plain, k_ring;
  logic [2*W-1:0] pl, pr;
  logic [N-1:0]   ring, ring_out;
  logic [2*N-1:0] cl, cr;

  assign k_plain = CNT_W'(32'(cnt_i) % W);
  assign k_ring  = CNT_W'(32'(cnt_i) % N);

  assign pl = {a_i, a_i} << k_plain;
  assign pr = {a_i, a_i} >> k_plain;

  assign ring = {cin_i, a_i};
  assign cl   = {ring, ring} << k_ring;
  assign cr   = {ring, ring} >> k_ring;
  assign ring_out = (op_i == OP_RCL) ? cl[2*N-1:N] : cr[N-1:0];

  always_comb begin
    unique case (op_i)
      OP_ROL: begin
        res_o   = pl[2*W-1:W];
        carry_o = pl[W];
      end
      OP_ROR: begin
        res_o   = pr[W-1:0];
        carry_o = pr[W-1];
      end
      default: begin
        res_o   = ring_out[W-1:0];
        carry_o = ring_out[W];
      end
    endcase
  end

endmodule

// File: rtl/srx_flag_gen.sv
module srx_flag_gen
  import srx_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [3:0]        op_i,
  input  logic              wide_i,
  input  logic              cnt_zero_i,
  input  logic              cnt_one_i,
  input  logic [WORD_W-1:0] opa_i,
  input  logic [WORD_W-1:0] sh_res_i,
  input  logic              sh_c_i,
  input  logic [WORD_W-1:0] rt_res_i,
  input  logic              rt_c_i,
  input  logic              cf_i,
  input  logic              zf_i,
  input  logic              sf_i,
  input  logic              of_i,
  output logic [WORD_W-1:0] res_o,
  output logic              cf_o,
  output logic              zf_o,
  output logic              sf_o,
  output logic              of_o
);

  localparam int BYTE_W = WORD_W / 2;

  logic rot, shf, keep, res_msb, opa_msb;

  assign rot  = is_rotate(op_i);
  assign shf  = is_shift(op_i);
  assign keep = cnt_zero_i || !(rot || shf);

  always_comb begin
    if (keep)     res_o = opa_i;
    else if (rot) res_o = rt_res_i;
    else          res_o = sh_res_i;
  end

  assign res_msb = wide_i ? res_o[WORD_W-1] : res_o[BYTE_W-1];
  assign opa_msb = wide_i ? opa_i[WORD_W-1] : opa_i[BYTE_W-1];

  assign cf_o = keep ? cf_i : (rot ? rt_c_i : sh_c_i);
  assign zf_o = (keep || rot) ? zf_i : (res_o == '0);
  assign sf_o = (keep || rot) ? sf_i : res_msb;
  assign of_o = (!keep && cnt_one_i) ? (res_msb ^ opa_msb) : of_i;

endmodule

// File: rtl/srx_unit.sv
module srx_unit
  import srx_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int CNT_W    = 5,
  parameter int CNT_IN_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [3:0]          op_i,
  input  logic                wide_i,
  input  logic [WORD_W-1:0]   opa_i,
  input  logic [WORD_W-1:0]   opb_i,
  input  logic [CNT_IN_W-1:0] count_i,
  input  logic                cf_i,
  input  logic                zf_i,
  input  logic                sf_i,
  input  logic                of_i,
  output logic                valid_o,
  output logic [WORD_W-1:0]   result_o,
  output logic                cf_o,
  output logic                zf_o,
  output logic                sf_o,
  output logic                of_o
);

  localparam int BYTE_W = WORD_W / 2;
  localparam logic [CNT_IN_W-1:0] CNT_MASK = CNT_IN_W'((1 << CNT_W) - 1);

  logic [CNT_IN_W-1:0] cnt_m;
  logic [WORD_W-1:0]   sh_res [2];
  logic [WORD_W-1:0]   rt_res [2];
  logic [1:0]          sh_c, rt_c;
  logic [WORD_W-1:0]   opa_w, res_d;
  logic                cf_d, zf_d, sf_d, of_d;

  assign cnt_m = count_i & CNT_MASK;
  assign opa_w = wide_i ? opa_i : {{(WORD_W-BYTE_W){1'b0}}, opa_i[BYTE_W-1:0]};

  // lane 0 = byte, lane 1 = word
  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam int LW = (g == 0) ? BYTE_W : WORD_W;
    logic [LW-1:0] s_res, r_res;
    logic          s_c, r_c;

    srx_shift_lane #(.W(LW), .CNT_W(CNT_IN_W)) i_shift (
      .op_i   (op_i),
      .a_i    (opa_i[LW-1:0]),
      .b_i    (opb_i[LW-1:0]),
      .cnt_i  (cnt_m),
      .res_o  (s_res),
      .carry_o(s_c)
    );

    srx_rot_lane #(.W(LW), .CNT_W(CNT_IN_W)) i_rot (
      .op_i   (op_i),
      .a_i    (opa_i[LW-1:0]),
      .cin_i  (cf_i),
      .cnt_i  (cnt_m),
      .res_o  (r_res),
      .carry_o(r_c)
    );

    assign sh_res[g] = WORD_W'(s_res);
    assign rt_res[g] = WORD_W'(r_res);
    assign sh_c[g]   = s_c;
    assign rt_c[g]   = r_c;
  end

  srx_flag_gen #(.WORD_W(WORD_W)) i_flags (
    .op_i      (op_i),
    .wide_i    (wide_i),
    .cnt_zero_i(cnt_m == '0),
    .cnt_one_i (cnt_m == CNT_IN_W'(1)),
    .opa_i     (opa_w),
    .sh_res_i  (sh_res[wide_i]),
    .sh_c_i    (sh_c[wide_i]),
    .rt_res_i  (rt_res[wide_i]),
    .rt_c_i    (rt_c[wide_i]),
    .cf_i      (cf_i),
    .zf_i      (zf_i),
    .sf_i      (sf_i),
    .of_i      (of_i),
    .res_o     (res_d),
    .cf_o      (cf_d),
    .zf_o      (zf_d),
    .sf_o      (sf_d),
    .of_o      (of_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      cf_o     <= 1'b0;
      zf_o     <= 1'b0;
      sf_o     <= 1'b0;
      of_o     <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_d;
        cf_o     <= cf_d;
        zf_o     <= zf_d;
        sf_o     <= sf_d;
        of_o     <= of_d;
      end
    end
  end

  p_valid_rise_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_valid_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  p_zero_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && wide_i && (count_i[CNT_W-1:0] == '0) |=>
      result_o == $past(opa_i) && cf_o == $past(cf_i) && zf_o == $past(zf_i) &&
      sf_o == $past(sf_i) && of_o == $past(of_i));

  p_of_kept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (count_i[CNT_W-1:0] > CNT_W'(1)) |=> of_o == $past(of_i));

  p_rot_keeps_zs_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_rotate(op_i) |=> zf_o == $past(zf_i) && sf_o == $past(sf_i));

  p_byte_upper_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !wide_i |=> result_o[WORD_W-1:BYTE_W] == '0);

  p_sar_sign_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && wide_i && op_i == OP_SAR |=> result_o[WORD_W-1] == $past(opa_i[WORD_W-1]));

endmodule

// File: tb/test_srx_unit.sv
module test_srx_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  op = '0;
  logic        wide = 1'b0;
  logic [15:0] opa = '0, opb = '0;
  logic [7:0]  cnt = '0;
  logic        cf_in = 1'b0, zf_in = 1'b0, sf_in = 1'b0, of_in = 1'b0;
  logic        valid_o;
  logic [15:0] result_o;
  logic        cf_o, zf_o, sf_o, of_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  srx_unit i_srx_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .wide_i(wide),
    .opa_i(opa), .opb_i(opb), .count_i(cnt),
    .cf_i(cf_in), .zf_i(zf_in), .sf_i(sf_in), .of_i(of_in),
    .valid_o(valid_o), .result_o(result_o),
    .cf_o(cf_o), .zf_o(zf_o), .sf_o(sf_o), .of_o(of_o)
  );

  // bit-serial reference: one position per step
  function automatic logic [19:0] model(logic [3:0] o, logic w, logic [15:0] a,
                                        logic [15:0] b, logic [7:0] n,
                                        logic ci, logic zi, logic si, logic oi);
    int W = w ? 16 : 8;
    int c = int'(n & 8'h1f);
    logic [15:0] m = w ? 16'hffff : 16'h00ff;
    logic [15:0] x = a & m;
    logic [15:0] y = b & m;
    logic [15:0] a0 = a & m;
    logic cf = ci, zf = zi, sf = si, of_ = oi, nb;
    if (c == 0 || o > 4'd9) return {x, ci, zi, si, oi};
    for (int i = 0; i < c; i++) begin
      case (o)
        4'd0, 4'd2: begin cf = x[W-1]; x = (x << 1) & m; end
        4'd1: begin cf = x[0]; x = x >> 1; end
        4'd3: begin cf = x[0]; x = (x >> 1) | (16'(x[W-1]) << (W-1)); end
        4'd4: begin cf = x[W-1]; x = ((x << 1) | 16'(cf)) & m; end
        4'd5: begin cf = x[0]; x = (x >> 1) | (16'(cf) << (W-1)); end
        4'd6: begin nb = x[W-1]; x = ((x << 1) | 16'(cf)) & m; cf = nb; end
        4'd7: begin nb = x[0]; x = (x >> 1) | (16'(cf) << (W-1)); cf = nb; end
        4'd8: begin cf = x[W-1]; x = ((x << 1) | 16'(y[W-1])) & m; y = (y << 1) & m; end
        default: begin cf = x[0]; x = (x >> 1) | (16'(y[0]) << (W-1)); y = y >> 1; end
      endcase
    end
    if (!(o >= 4'd4 && o <= 4'd7)) begin
      zf = (x == 16'h0);
      sf = x[W-1];
    end
    if (c == 1) of_ = x[W-1] ^ a0[W-1];
    return {x, cf, zf, sf, of_};
  endfunction

  function automatic string tag_of(logic [3:0] o);
    case (o)
      4'd0, 4'd2: return "R1";
      4'd1: return "R2";
      4'd3: return "R3";
      4'd4, 4'd5: return "R4";
      4'd6, 4'd7: return "R5";
      4'd8, 4'd9: return "R6";
      default: return "R12";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [19:0] got, logic [19:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // one request; outputs sampled on the following falling edge
  task automatic run(string tag, logic [3:0] o, logic w, logic [15:0] a, logic [15:0] b,
                     logic [7:0] n, logic [3:0] fl);
    logic [19:0] exp = model(o, w, a, b, n, fl[3], fl[2], fl[1], fl[0]);
    @(negedge clk);
    valid = 1'b1; op = o; wide = w; opa = a; opb = b; cnt = n;
    {cf_in, zf_in, sf_in, of_in} = fl;
    @(negedge clk);
    valid = 1'b0;
    check(tag, "valid", {19'd0, valid_o}, 20'd1);
    check(tag, "result+flags", {result_o, cf_o, zf_o, sf_o, of_o}, exp);
  endtask

  // directed: also check result and carry against a hand value
  task automatic run_exp(string tag, logic [3:0] o, logic w, logic [15:0] a, logic [15:0] b,
                         logic [7:0] n, logic [3:0] fl, logic [15:0] er, logic ec);
    run(tag, o, w, a, b, n, fl);
    check(tag, "hand result+carry", {3'd0, result_o, cf_o}, {3'd0, er, ec});
  endtask

  task automatic test_reset();
    check("R12", "reset state", {3'd0, valid_o, result_o}, 20'd0);
    check("R12", "reset flags", {16'd0, cf_o, zf_o, sf_o, of_o}, 20'd0);
  endtask

  task automatic test_shifts();
    run_exp("R1", 4'd0, 1'b1, 16'h8001, 16'h0, 8'd1,  4'b0000, 16'h0002, 1'b1);
    run_exp("R1", 4'd2, 1'b1, 16'h0001, 16'h0, 8'd16, 4'b0000, 16'h0000, 1'b1);
    run_exp("R1", 4'd0, 1'b1, 16'h0001, 16'h0, 8'd17, 4'b0000, 16'h0000, 1'b0);
    run_exp("R2", 4'd1, 1'b0, 16'h0081, 16'h0, 8'd1,  4'b0000, 16'h0040, 1'b1);
    run_exp("R2", 4'd1, 1'b1, 16'hffff, 16'h0, 8'd16, 4'b0000, 16'h0000, 1'b1);
    run_exp("R3", 4'd3, 1'b1, 16'h8000, 16'h0, 8'd20, 4'b0001, 16'hffff, 1'b1);
  endtask

  task automatic test_rotates();
    run_exp("R4", 4'd4, 1'b0, 16'h0081, 16'h0, 8'd1,  4'b0000, 16'h0003, 1'b1);
    run_exp("R4", 4'd5, 1'b1, 16'h0001, 16'h0, 8'd1,  4'b0000, 16'h8000, 1'b1);
    run_exp("R5", 4'd7, 1'b0, 16'h0001, 16'h0, 8'd1,  4'b1000, 16'h0080, 1'b1);
    run_exp("R5", 4'd6, 1'b1, 16'h5a3c, 16'h0, 8'd17, 4'b1000, 16'h5a3c, 1'b1);
  endtask

  task automatic test_funnel();
    run_exp("R6", 4'd8, 1'b1, 16'h1234, 16'habcd, 8'd4, 4'b0000, 16'h234a, 1'b1);
    run_exp("R6", 4'd9, 1'b1, 16'h1234, 16'habcd, 8'd4, 4'b0000, 16'hd123, 1'b0);
  endtask

  task automatic test_count_edges();
    run_exp("R7",  4'd0, 1'b1, 16'h0001, 16'h0, 8'h21, 4'b0000, 16'h0002, 1'b0);
    run_exp("R8",  4'd0, 1'b1, 16'h1234, 16'h0, 8'he0, 4'b1011, 16'h1234, 1'b1);
    run_exp("R12", 4'hf, 1'b1, 16'h4321, 16'h0, 8'd3,  4'b0110, 16'h4321, 1'b0);
    run_exp("R11", 4'd0, 1'b0, 16'hff80, 16'h0, 8'd1,  4'b0000, 16'h0000, 1'b1);
  endtask

  task automatic test_flags();
    run("R9",  4'd3, 1'b1, 16'h8000, 16'h0, 8'd1, 4'b0001);
    check("R9", "sar by one clears overflow", {19'd0, of_o}, 20'd0);
    run("R9",  4'd0, 1'b1, 16'h4000, 16'h0, 8'd2, 4'b0001);
    check("R9", "overflow kept for count 2", {19'd0, of_o}, 20'd1);
    run("R10", 4'd4, 1'b1, 16'h0000, 16'h0, 8'd3, 4'b0010);
    check("R10", "rotate keeps zero/sign", {18'd0, zf_o, sf_o}, {18'd0, 2'b01});
  endtask

  task automatic test_sweep();
    logic [15:0] pats [3] = '{16'h8001, 16'h5a3c, 16'hc3f0};
    for (int o = 0; o < 10; o++)
      for (int w = 0; w < 2; w++)
        for (int p = 0; p < 3; p++)
          for (int c = 0; c < 32; c++)
            run(tag_of(4'(o)), 4'(o), w[0], pats[p], pats[(p + 1) % 3],
                8'(c) | ((c % 3 == 1) ? 8'ha0 : 8'h00), 4'(c + p));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_shifts();
    test_rotates();
    test_funnel();
    test_count_edges();
    test_flags();
    test_sweep();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule